// File: doc/BRIEF.md
# Framed Serial Word Loader with Staged Commit

This block takes 16-bit command words from a three-wire serial port: an active-low frame strobe, a serial clock and a data line. Bits are taken on the falling serial-clock edge, most significant first. The top nibble of a word is an opcode. The next nibble is a target address, and the low byte is a payload. Two opcodes place the payload into the low or the high byte of a 16-bit staging register. A third opcode writes the whole staging register to the addressed register of the oscillator core, as a one-cycle write strobe with address and data. A fourth opcode updates the selection and power-down control outputs directly.

A 32-bit tuning word is written as two 16-bit halves. The two halves use separate commit addresses. Because the staging register only reaches the core on a commit, a half updates in one cycle and never shows a half-written value. A completed serial word is handed to the master-clock domain with a toggle flag and a two-flop synchronizer. A frame that closes early is dropped.

Top module: `serial_word_loader`

## Requirements
- R1: After reset, wr_stb is 0, wr_addr and wr_data are 0, freq_sel, phase_sel and src_sel are 0, and pwr_down is 1.
- R2: While frame_n is low, one data bit is taken on each falling edge of sclk, most significant bit first. The first 16 bits form one word: opcode = bits 15:12, address = bits 11:8, payload = bits 7:0.
- R3: Opcode 0 writes the payload into bits 7:0 of the staging register. Opcode 1 writes it into bits 15:8. Neither opcode produces a write strobe.
- R4: Opcode 2 produces one write strobe. It carries wr_addr = word bits 11:8 and wr_data = the current staging register.
- R5: A commit leaves the staging register unchanged, so a second commit carries the same data.
- R6: Opcode 3 sets freq_sel = payload bit 0, phase_sel = payload bits 2:1, src_sel = payload bit 3 and pwr_down = payload bit 4. No other word changes these outputs.
- R7: If frame_n rises before the 16th falling edge, the partial word is discarded. It causes no strobe and no change to the staging register or the controls.
- R8: wr_stb is high for exactly one master-clock cycle per commit. It rises within six master-clock cycles of the 16th falling sclk edge, given a serial clock much slower than the master clock.
- R9: Opcodes 4 to 15 are ignored. They cause no strobe and no change to the staging register or the controls.
- R10: Bits sent after the 16th in the same frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| frame_n | input | 1 | Active-low frame strobe marking one word |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Target register address of the write |
| wr_data | output | 16 | Committed staging-register contents |
| freq_sel | output | 1 | Frequency register select bit |
| phase_sel | output | 2 | Phase register select bits |
| src_sel | output | 1 | Selection source bit |
| pwr_down | output | 1 | Power-down control |

## Verification
The staging register has no port of its own, so a wrong byte lane or a lost load shows up only on the next commit, as wrong wr_data. The bench therefore follows every load sequence with a commit and compares the strobe payload. A bit counter that fails to clear on an early frame end, or that does not stop at 16 bits, misaligns the following word. That corrupts the next strobe or the control outputs within one frame. A handshake fault shows as a missing, doubled or late strobe, which the scoreboard sees within a few master cycles of the last serial edge.

// File: rtl/serial_word_loader.sv
module serial_word_loader #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              frame_n,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              freq_sel,
  output logic [1:0]        phase_sel,
  output logic              src_sel,
  output logic              pwr_down
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int BYTE_W = WORD_W / 2;
  localparam int OP_W   = WORD_W - BYTE_W - ADDR_W;

  localparam logic [OP_W-1:0] OP_LO     = OP_W'(0);
  localparam logic [OP_W-1:0] OP_HI     = OP_W'(1);
  localparam logic [OP_W-1:0] OP_COMMIT = OP_W'(2);
  localparam logic [OP_W-1:0] OP_CTRL   = OP_W'(3);

  logic [WORD_W-1:0] shreg, hold, defer;
  logic [CNT_W-1:0]  bitcnt;
  logic              tgl;
  logic [2:0]        sync;

  wire fclr = frame_n | ~rst_n;

  always_ff @(negedge sclk or posedge fclr) begin
    if (fclr) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (bitcnt != CNT_W'(WORD_W)) begin
      shreg  <= {shreg[WORD_W-2:0], sdata};
      bitcnt <= bitcnt + 1'b1;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      tgl  <= 1'b0;
      hold <= '0;
    end else if (!frame_n && bitcnt == CNT_W'(WORD_W - 1)) begin
      hold <= {shreg[WORD_W-2:0], sdata};
      tgl  <= ~tgl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], tgl};
  end

  wire              take    = sync[2] ^ sync[1];
  wire [OP_W-1:0]   op      = hold[WORD_W-1 -: OP_W];
  wire [ADDR_W-1:0] addr    = hold[BYTE_W +: ADDR_W];
  wire [BYTE_W-1:0] payload = hold[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer     <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      freq_sel  <= 1'b0;
      phase_sel <= 2'b00;
      src_sel   <= 1'b0;
      pwr_down  <= 1'b1;
    end else begin
      wr_stb <= 1'b0;
      if (take) begin
        case (op)
          OP_LO:     defer[BYTE_W-1:0] <= payload;
          OP_HI:     defer[WORD_W-1:BYTE_W] <= payload;
          OP_COMMIT: begin
            wr_stb  <= 1'b1;
            wr_addr <= addr;
            wr_data <= defer;
          end
          OP_CTRL: begin
            freq_sel  <= payload[0];
            phase_sel <= payload[2:1];
            src_sel   <= payload[3];
            pwr_down  <= payload[4];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module serial_word_loader_chk #(
  parameter int ADDR_W = 4,
  parameter int OP_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take,
  input logic [OP_W-1:0]   op,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              freq_sel,
  input logic [1:0]        phase_sel,
  input logic              src_sel,
  input logic              pwr_down
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r4_commit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_W'(2)) |=> (wr_stb && wr_addr == $past(addr)));

  a_r4_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(take && op == OP_W'(2)));

  a_r3_load_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op != OP_W'(2)) |=> !wr_stb);

  a_r6_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && op == OP_W'(3)) |=> $stable({freq_sel, phase_sel, src_sel, pwr_down}));
endmodule

bind serial_word_loader serial_word_loader_chk #(.ADDR_W(ADDR_W), .OP_W(OP_W)) chk (
  .clk(clk), .rst_n(rst_n), .take(take), .op(op), .addr(addr),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .freq_sel(freq_sel),
  .phase_sel(phase_sel), .src_sel(src_sel), .pwr_down(pwr_down)
);

// File: tb/serial_word_loader_test.sv
module serial_word_loader_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, sdata = 1'b0, frame_n = 1'b1;
  logic        wr_stb;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        freq_sel, src_sel, pwr_down;
  logic [1:0]  phase_sel;

  int checks = 0, errors = 0;
  logic [19:0] expq[$];
  time t_last = 0;
  logic prev_stb = 1'b0;

  always #4 clk = ~clk;

  serial_word_loader uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .frame_n(frame_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .src_sel(src_sel), .pwr_down(pwr_down)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input logic [3:0] extra);
    frame_n = 1'b0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[15-i] : extra[19-i];
      sclk = 1'b1; #16;
      sclk = 1'b0;
      if (i == 15) t_last = $time;
      #16;
    end
    sclk = 1'b1; #16;
    frame_n = 1'b1;
    #120;
  endtask

  task automatic commit(input logic [3:0] a, input logic [15:0] expdata);
    expq.push_back({a, expdata});
    send({4'h2, a, 8'h5A}, 16, 4'h0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb && prev_stb) check("R8 strobe width", 1, 0);
      if (wr_stb && !prev_stb) begin
        if (expq.size() == 0) check("R7/R9 unexpected strobe", {12'h0, wr_addr, wr_data}, 0);
        else begin
          logic [19:0] e;
          e = expq.pop_front();
          check("R4 strobe addr/data", {12'h0, wr_addr, wr_data}, {12'h0, e});
          check("R8 strobe latency", (($time - t_last) <= 48) ? 1 : 0, 1);
        end
      end
    end
    prev_stb = wr_stb;
  end

  task automatic ctrl_check(input logic f, input logic [1:0] p, input logic s, input logic pd);
    check("R6 freq_sel", freq_sel, f);
    check("R6 phase_sel", phase_sel, p);
    check("R6 src_sel", src_sel, s);
    check("R6 pwr_down", pwr_down, pd);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 wr_stb", wr_stb, 0);
    check("R1 wr_addr/wr_data", {wr_addr, wr_data}, 0);
    ctrl_check(0, 2'b00, 0, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4: byte lanes and commit
    send(16'h0034, 16, 4'h0);
    send(16'h1112, 16, 4'h0);
    commit(4'h5, 16'h1234);
    // R5: defer kept after commit
    commit(4'h6, 16'h1234);
    send(16'h10AB, 16, 4'h0);
    commit(4'h0, 16'hAB34);

    // R6: control word fields
    send(16'h3015, 16, 4'h0);
    ctrl_check(1, 2'b10, 0, 1);
    send(16'h370E, 16, 4'h0);
    ctrl_check(0, 2'b11, 1, 0);

    // R7: truncated frames discarded
    send(16'h2900, 10, 4'h0);
    send(16'h00FF, 8, 4'h0);
    send(16'h3000, 15, 4'h0);
    ctrl_check(0, 2'b11, 1, 0);
    commit(4'h1, 16'hAB34);

    // R9: unknown opcodes ignored
    send(16'h4077, 16, 4'h0);
    send(16'hF0FF, 16, 4'h0);
    send(16'h9300, 16, 4'h0);
    ctrl_check(0, 2'b11, 1, 0);
    commit(4'h2, 16'hAB34);

    // R10: extra bits in frame ignored
    send(16'h0056, 20, 4'hF);
    commit(4'h3, 16'hAB56);
    send(16'h3001, 20, 4'hF);
    ctrl_check(1, 2'b00, 0, 0);

    repeat (10) @(negedge clk);
    check("R4/R7 all commits seen", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule